// File: doc/BRIEF.md
# SD Host Command and Response Unit

This unit is the command half of a memory-card host controller. Software programs an argument and a command word over a simple 32-bit register bus. Writing the command word launches one card-side request: a one-cycle strobe together with a 6-bit command index and the 32-bit argument. The card side then returns the response as a stream of bytes, followed by a completion strobe that carries the response length.

When the completion arrives, the unit checks the length against what the command asked for. It packs good responses into four response words and echoes the command index into a response-command register. It then sets one of three completion status bits. An interrupt line is raised whenever an enabled status bit is set. Status bits are cleared by writing ones to them. A soft-reset control bit returns the register set to its idle values and leaves some status bits as they were. Line CRC, clock generation and the data path are outside this unit.

Top module: `sd_cmd_unit`

## Requirements
- R1: A write to the command register (word address 0) while the unit is idle makes `card_req` high for exactly one cycle, on the cycle after the write. During that cycle `card_cmd_idx` equals bits 5:0 of the written word and `card_arg` equals the argument register (word address 1).
- R2: A command write while a command is outstanding is ignored. No strobe is issued, the command register keeps its value, and status bit 31 (busy) stays high until the completion strobe.
- R3: When command bit 6 (expect response) is clear, the completion strobe sets status bit 2 (command sent) and leaves the response words unchanged, whatever length is reported.
- R4: When command bit 6 is set and the length is 4, bytes 0..3 are placed big-endian into response word 0, with byte 0 in bits 31:24. Response words 1..3 (addresses 3..5) become zero and status bit 1 (response received) is set.
- R5: When command bit 6 is set and the length is 16, the response is stored as follows, each word big-endian: bytes 0..3 go to response word 3, bytes 4..7 to word 2, bytes 8..11 to word 1 and bytes 12..15 to word 0. Bit 0 of word 0 is then forced to 0. Status bit 1 is set. This also applies when command bit 7 (long response) is clear.
- R6: When command bit 6 is set, a length of 0, a length of 4 with command bit 7 set, or any length other than 4 or 16 sets status bit 0 (response timeout). The response words and the response-command register are left unchanged.
- R7: On a good response, the response-command register (address 6) holds the command index in bits 5:0 and a copy of command bit 8 in bit 6.
- R8: `irq` is high exactly when the AND of the interrupt-enable register (address 8) and status bits 6:0 is nonzero.
- R9: Writing the status register (address 7) clears each status bit 6:0 whose written bit is 1 and leaves the others. If a hardware event sets a bit in the same cycle, the set wins.
- R10: Writing 1 to bit 0 of the control register (address 14) clears the command, argument, response, response-command, enable, data-control, timer, length, power and clock registers and the busy flag. It also clears status bits 3 and 4, sets status bits 5 and 6 (transmit/receive ready) and keeps status bits 0..2. After hardware reset the status reads 0x60.
- R11: A pulse on `card_removed_evt` sets status bit 3, and a pulse on `card_wprot_evt` sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| card_req | output | 1 | One-cycle command request to the card side |
| card_cmd_idx | output | 6 | Command index sent with the request |
| card_arg | output | 32 | Command argument sent with the request |
| card_rsp_byte_vld | input | 1 | A response byte is present |
| card_rsp_byte | input | 8 | Response byte, first byte first |
| card_rsp_done | input | 1 | Response complete strobe |
| card_rsp_len | input | 5 | Response length in bytes, valid with `card_rsp_done` |
| card_removed_evt | input | 1 | Card removal event |
| card_wprot_evt | input | 1 | Write-protect event |

## Verification
The hardest situations to reach from the ports are the ones in which a command is still outstanding. These are a second command write that must be refused, and a soft reset that must drop the busy flag with no completion. The bench reaches them by issuing a command and then holding the card side silent, so the unit stays busy while the refused write and the soft reset are applied. The length-mismatch cases and a 16-byte reply to a command that asked for a short response are fed from the vector table. A reference model in the bench tracks which response words must stay unchanged.

// File: rtl/sdcu_pkg.sv
`timescale 1ns/1ps
package sdcu_pkg;
    localparam int DW = 32;

    localparam logic [3:0] A_CMD    = 4'd0;
    localparam logic [3:0] A_ARG    = 4'd1;
    localparam logic [3:0] A_RSP0   = 4'd2;
    localparam logic [3:0] A_RSP1   = 4'd3;
    localparam logic [3:0] A_RSP2   = 4'd4;
    localparam logic [3:0] A_RSP3   = 4'd5;
    localparam logic [3:0] A_RSPCMD = 4'd6;
    localparam logic [3:0] A_STAT   = 4'd7;
    localparam logic [3:0] A_IEN    = 4'd8;
    localparam logic [3:0] A_DCTL   = 4'd9;
    localparam logic [3:0] A_DTMR   = 4'd10;
    localparam logic [3:0] A_DLEN   = 4'd11;
    localparam logic [3:0] A_PWR    = 4'd12;
    localparam logic [3:0] A_CLK    = 4'd13;
    localparam logic [3:0] A_CTRL   = 4'd14;

    localparam int ST_W    = 7;
    localparam int ST_TO   = 0;
    localparam int ST_OK   = 1;
    localparam int ST_SENT = 2;
    localparam int ST_GONE = 3;
    localparam int ST_WP   = 4;
    localparam int ST_TXR  = 5;
    localparam int ST_RXR  = 6;
    localparam logic [ST_W-1:0] ST_IDLE = (ST_W'(1) << ST_TXR) | (ST_W'(1) << ST_RXR);

    localparam int CMD_WAIT = 6;
    localparam int CMD_LONG = 7;
    localparam int CMD_APP  = 8;
endpackage

// File: rtl/sdcu_rsp_collect.sv
`timescale 1ns/1ps
module sdcu_rsp_collect #(
    parameter int RSP_BYTES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_i,
    input  logic                       vld_i,
    input  logic [7:0]                 byte_i,
    output logic [RSP_BYTES-1:0][7:0]  bytes_o
);
    localparam int CNT_W = $clog2(RSP_BYTES + 1);
    localparam int IX_W  = $clog2(RSP_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0]           cnt;
        logic [RSP_BYTES-1:0][7:0]  data;
    } col_t;

    col_t col_d, col_q;

    always_comb begin
        col_d = col_q;
        if (clear_i) begin
            col_d.cnt = '0;
        end else if (vld_i && (col_q.cnt < CNT_W'(RSP_BYTES))) begin
            col_d.data[col_q.cnt[IX_W-1:0]] = byte_i;
            col_d.cnt = col_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign bytes_o = col_q.data;

    // R4/R5: byte count never passes the buffer size
    p_cnt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q.cnt == CNT_W'(RSP_BYTES)) |=> (col_q.cnt == CNT_W'(RSP_BYTES)) || $past(clear_i));
endmodule

// File: rtl/sdcu_rsp_pack.sv
`timescale 1ns/1ps
module sdcu_rsp_pack #(
    parameter int RSP_BYTES = 16,
    parameter int LEN_W     = 5
) (
    input  logic [RSP_BYTES-1:0][7:0]       bytes_i,
    input  logic [LEN_W-1:0]                len_i,
    input  logic                            long_req_i,
    output logic [RSP_BYTES/4-1:0][31:0]    words_o,
    output logic                            err_o
);
    localparam int WORDS = RSP_BYTES / 4;
    localparam logic [LEN_W-1:0] SHORT_LEN = LEN_W'(4);
    localparam logic [LEN_W-1:0] LONG_LEN  = LEN_W'(RSP_BYTES);

    logic                   is_short, is_long;
    logic [WORDS-1:0][31:0] long_w;

    assign is_short = (len_i == SHORT_LEN);
    assign is_long  = (len_i == LONG_LEN);
    assign err_o    = (len_i == '0) || (is_short && long_req_i) || !(is_short || is_long);

    // first byte on the wire lands in the highest word, most significant byte first
    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            long_w[w] = {bytes_i[4*(WORDS-1-w)],     bytes_i[4*(WORDS-1-w) + 1],
                         bytes_i[4*(WORDS-1-w) + 2], bytes_i[4*(WORDS-1-w) + 3]};
        end
        long_w[0][0] = 1'b0;
    end

    always_comb begin
        words_o = '0;
        if (is_long) words_o = long_w;
        else         words_o[0] = {bytes_i[0], bytes_i[1], bytes_i[2], bytes_i[3]};
    end
endmodule

// File: rtl/sd_cmd_unit.sv
`timescale 1ns/1ps
module sd_cmd_unit
    import sdcu_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int LEN_W     = 5,
    parameter int RSP_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq,
    output logic              card_req,
    output logic [IDX_W-1:0]  card_cmd_idx,
    output logic [DW-1:0]     card_arg,
    input  logic              card_rsp_byte_vld,
    input  logic [7:0]        card_rsp_byte,
    input  logic              card_rsp_done,
    input  logic [LEN_W-1:0]  card_rsp_len,
    input  logic              card_removed_evt,
    input  logic              card_wprot_evt
);
    localparam int RSP_WORDS = RSP_BYTES / 4;
    localparam int RC_W      = IDX_W + 1;

    typedef struct packed {
        logic [DW-1:0]                  cmd;
        logic [DW-1:0]                  arg;
        logic [RSP_WORDS-1:0][DW-1:0]   rsp;
        logic [RC_W-1:0]                rspcmd;
        logic [ST_W-1:0]                status;
        logic [DW-1:0]                  ien;
        logic [DW-1:0]                  dctl;
        logic [DW-1:0]                  dtmr;
        logic [DW-1:0]                  dlen;
        logic [DW-1:0]                  pwr;
        logic [DW-1:0]                  clkdiv;
        logic                           busy;
        logic                           req;
    } unit_t;

    unit_t st_d, st_q;

    logic                         launch, finish, soft_rst;
    logic [RSP_BYTES-1:0][7:0]    rsp_bytes;
    logic [RSP_WORDS-1:0][DW-1:0] packed_words;
    logic                         len_err;

    assign launch   = reg_wr && (reg_addr == A_CMD) && !st_q.busy;
    assign finish   = card_rsp_done && st_q.busy;
    assign soft_rst = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];

    sdcu_rsp_collect #(.RSP_BYTES(RSP_BYTES)) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (launch),
        .vld_i   (card_rsp_byte_vld),
        .byte_i  (card_rsp_byte),
        .bytes_o (rsp_bytes)
    );

    sdcu_rsp_pack #(.RSP_BYTES(RSP_BYTES), .LEN_W(LEN_W)) u_pack (
        .bytes_i    (rsp_bytes),
        .len_i      (card_rsp_len),
        .long_req_i (st_q.cmd[CMD_LONG]),
        .words_o    (packed_words),
        .err_o      (len_err)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;

        if (reg_wr) begin
            case (reg_addr)
                A_ARG:  st_d.arg    = reg_wdata;
                A_STAT: st_d.status = st_q.status & ~reg_wdata[ST_W-1:0];
                A_IEN:  st_d.ien    = reg_wdata;
                A_DCTL: st_d.dctl   = reg_wdata;
                A_DTMR: st_d.dtmr   = reg_wdata;
                A_DLEN: st_d.dlen   = reg_wdata;
                A_PWR:  st_d.pwr    = reg_wdata;
                A_CLK:  st_d.clkdiv = reg_wdata;
                default: ;
            endcase
        end

        if (card_removed_evt) st_d.status[ST_GONE] = 1'b1;
        if (card_wprot_evt)   st_d.status[ST_WP]   = 1'b1;

        if (launch) begin
            st_d.cmd  = reg_wdata;
            st_d.busy = 1'b1;
            st_d.req  = 1'b1;
        end

        if (finish) begin
            st_d.busy = 1'b0;
            if (!st_q.cmd[CMD_WAIT]) begin
                st_d.status[ST_SENT] = 1'b1;
            end else if (len_err) begin
                st_d.status[ST_TO] = 1'b1;
            end else begin
                st_d.rsp           = packed_words;
                st_d.rspcmd        = {st_q.cmd[CMD_APP], st_q.cmd[IDX_W-1:0]};
                st_d.status[ST_OK] = 1'b1;
            end
        end

        if (soft_rst) begin
            st_d        = '0;
            st_d.status = (st_q.status & ~((ST_W'(1) << ST_GONE) | (ST_W'(1) << ST_WP))) | ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.status <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CMD:    reg_rdata = st_q.cmd;
            A_ARG:    reg_rdata = st_q.arg;
            A_RSP0:   reg_rdata = st_q.rsp[0];
            A_RSP1:   reg_rdata = st_q.rsp[1];
            A_RSP2:   reg_rdata = st_q.rsp[2];
            A_RSP3:   reg_rdata = st_q.rsp[3];
            A_RSPCMD: reg_rdata = DW'(st_q.rspcmd);
            A_STAT:   reg_rdata = {st_q.busy, {(DW-1-ST_W){1'b0}}, st_q.status};
            A_IEN:    reg_rdata = st_q.ien;
            A_DCTL:   reg_rdata = st_q.dctl;
            A_DTMR:   reg_rdata = st_q.dtmr;
            A_DLEN:   reg_rdata = st_q.dlen;
            A_PWR:    reg_rdata = st_q.pwr;
            A_CLK:    reg_rdata = st_q.clkdiv;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq          = |(st_q.ien[ST_W-1:0] & st_q.status);
    assign card_req     = st_q.req;
    assign card_cmd_idx = st_q.cmd[IDX_W-1:0];
    assign card_arg     = st_q.arg;

    p_req_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |=> !card_req);

    p_req_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |-> $past(reg_wr && (reg_addr == A_CMD) && !st_q.busy));

    p_busy_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rsp_done && st_q.busy) |=> !st_q.busy);

    p_long_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rsp_done && st_q.busy && st_q.cmd[CMD_WAIT] && (card_rsp_len == LEN_W'(RSP_BYTES)))
        |=> (st_q.rsp[0][0] == 1'b0));

    p_zero_len_to_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rsp_done && st_q.busy && st_q.cmd[CMD_WAIT] && (card_rsp_len == '0) && !soft_rst)
        |=> st_q.status[ST_TO]);

    p_soft_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q.cmd == '0) && !st_q.busy && st_q.status[ST_TXR] && st_q.status[ST_RXR]);
endmodule

// File: tb/sd_cmd_unit_tb.sv
`timescale 1ns/1ps
module sd_cmd_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, card_req;
    logic [5:0]  card_cmd_idx;
    logic [31:0] card_arg;
    logic        bvld = 1'b0;
    logic [7:0]  bdat = '0;
    logic        done = 1'b0;
    logic [4:0]  dlen = '0;
    logic        ev_gone = 1'b0;
    logic        ev_wp = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] m_rsp [4];
    logic [31:0] m_rspcmd;

    always #10 clk = ~clk;

    sd_cmd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .card_req(card_req), .card_cmd_idx(card_cmd_idx), .card_arg(card_arg),
        .card_rsp_byte_vld(bvld), .card_rsp_byte(bdat), .card_rsp_done(done),
        .card_rsp_len(dlen), .card_removed_evt(ev_gone), .card_wprot_evt(ev_wp)
    );

    typedef struct packed {
        logic [31:0]  cmd;
        logic [31:0]  arg;
        logic [4:0]   len;
        logic [127:0] seed;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{32'h000, 32'h0000_0000, 5'd0,  128'h0},
        '{32'h051, 32'h0000_01AA, 5'd4,  128'hDEADBEEF_01234567_89ABCDEF_0F1E2D3D},
        '{32'h0C2, 32'h1234_5678, 5'd16, 128'h11223344_55667788_99AABBCC_DDEEFF01},
        '{32'h149, 32'hFFFF_0000, 5'd4,  128'hA5A55A5A_00000000_00000000_00000000},
        '{32'h0C3, 32'h0000_0003, 5'd4,  128'h01020304_05060708_090A0B0C_0D0E0F10},
        '{32'h04D, 32'h8000_0001, 5'd0,  128'h0},
        '{32'h048, 32'h0000_0048, 5'd6,  128'hCAFEF00D_BEEF0000_00000000_00000000},
        '{32'h04A, 32'h0000_004A, 5'd16, 128'h0F0E0D0C_0B0A0908_07060504_03020103},
        '{32'h00C, 32'h0000_000C, 5'd4,  128'h77777777_00000000_00000000_00000000}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic card_reply(input logic [127:0] seed, input logic [4:0] len);
        for (int k = 0; k < 16 && k < int'(len); k++) begin
            @(negedge clk);
            bvld = 1'b1; bdat = seed[127-8*k -: 8];
        end
        @(negedge clk);
        bvld = 1'b0; done = 1'b1; dlen = len;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] rd, exp_st;
        logic        err;
        string       tg;
        bus_wr(4'd1, v.arg);
        bus_wr(4'd0, v.cmd);
        chk(card_req === 1'b1, "R1 strobe", {31'b0, card_req}, 32'd1);
        chk(card_cmd_idx === v.cmd[5:0], "R1 index", {26'b0, card_cmd_idx}, {26'b0, v.cmd[5:0]});
        chk(card_arg === v.arg, "R1 argument", card_arg, v.arg);
        @(negedge clk);
        chk(card_req === 1'b0, "R1 single cycle", {31'b0, card_req}, 32'd0);
        card_reply(v.seed, v.len);
        err = (v.len == 0) || (v.len == 4 && v.cmd[7]) || (v.len != 4 && v.len != 16);
        if (!v.cmd[6]) begin
            exp_st = 32'h64; tg = "R3 status";
        end else if (err) begin
            exp_st = 32'h61; tg = "R6 status";
        end else begin
            exp_st = 32'h62; tg = (v.len == 16) ? "R5 status" : "R4 status";
            m_rspcmd = {25'b0, v.cmd[8], v.cmd[5:0]};
            if (v.len == 4) begin
                m_rsp[0] = v.seed[127:96]; m_rsp[1] = '0; m_rsp[2] = '0; m_rsp[3] = '0;
            end else begin
                m_rsp[3] = v.seed[127:96]; m_rsp[2] = v.seed[95:64];
                m_rsp[1] = v.seed[63:32];  m_rsp[0] = v.seed[31:0] & 32'hFFFF_FFFE;
            end
        end
        bus_rd(4'd7, rd);
        chk(rd === exp_st, tg, rd, exp_st);
        for (int w = 0; w < 4; w++) begin
            bus_rd(4'(2 + w), rd);
            chk(rd === m_rsp[w], "R4/R5/R6 response word (R5)", rd, m_rsp[w]);
        end
        bus_rd(4'd6, rd);
        chk(rd === m_rspcmd, "R7 response command", rd, m_rspcmd);
        bus_wr(4'd7, 32'h7);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        for (int w = 0; w < 4; w++) m_rsp[w] = '0;
        m_rspcmd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R10)
        bus_rd(4'd7, rd);
        chk(rd === 32'h60, "R10 reset status", rd, 32'h60);
        bus_rd(4'd0, rd);
        chk(rd === 32'h0, "R10 reset command", rd, 32'h0);
        chk(irq === 1'b0 && card_req === 1'b0, "R8 reset outputs", {30'b0, irq, card_req}, 32'd0);

        // vector table: R1 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R8 interrupt
        bus_wr(4'd8, 32'h20);
        @(negedge clk);
        chk(irq === 1'b1, "R8 enabled ready bit", {31'b0, irq}, 32'd1);
        bus_wr(4'd8, 32'h01);
        @(negedge clk);
        chk(irq === 1'b0, "R8 masked", {31'b0, irq}, 32'd0);
        bus_wr(4'd1, 32'h0);
        bus_wr(4'd0, 32'h045);
        card_reply(128'h0, 5'd0);
        chk(irq === 1'b1, "R8 timeout raises irq", {31'b0, irq}, 32'd1);
        bus_wr(4'd7, 32'h01);
        chk(irq === 1'b0, "R9 clear drops irq", {31'b0, irq}, 32'd0);

        // R11 events, R9 write-one-to-clear
        @(negedge clk); ev_gone = 1'b1;
        @(negedge clk); ev_gone = 1'b0; ev_wp = 1'b1;
        @(negedge clk); ev_wp = 1'b0;
        bus_rd(4'd7, rd);
        chk(rd === 32'h78, "R11 event bits", rd, 32'h78);
        bus_wr(4'd7, 32'h0);
        bus_rd(4'd7, rd);
        chk(rd === 32'h78, "R9 zero write keeps", rd, 32'h78);
        bus_wr(4'd7, 32'h08);
        bus_rd(4'd7, rd);
        chk(rd === 32'h70, "R9 selective clear", rd, 32'h70);

        // R2 refused write while busy
        bus_wr(4'd0, 32'h041);
        @(negedge clk);
        bus_wr(4'd0, 32'h007);
        chk(card_req === 1'b0, "R2 no second strobe", {31'b0, card_req}, 32'd0);
        bus_rd(4'd0, rd);
        chk(rd === 32'h041, "R2 command kept", rd, 32'h041);
        bus_rd(4'd7, rd);
        chk(rd[31] === 1'b1, "R2 busy shown", {31'b0, rd[31]}, 32'd1);
        card_reply(128'h89ABCDEF_00000000_00000000_00000000, 5'd4);
        bus_rd(4'd2, rd);
        chk(rd === 32'h89ABCDEF, "R2 first command completes", rd, 32'h89ABCDEF);
        bus_rd(4'd7, rd);
        chk(rd === 32'h72, "R2 busy released", rd, 32'h72);

        // R10 soft reset mid-command
        bus_wr(4'd7, 32'h7F);
        bus_wr(4'd12, 32'h5);
        bus_wr(4'd13, 32'h7);
        bus_wr(4'd9, 32'h3);
        bus_wr(4'd8, 32'hFF);
        bus_wr(4'd1, 32'h55);
        bus_wr(4'd0, 32'h00D);
        card_reply(128'h0, 5'd0);
        @(negedge clk); ev_wp = 1'b1;
        @(negedge clk); ev_wp = 1'b0;
        bus_wr(4'd0, 32'h042);
        bus_rd(4'd7, rd);
        chk(rd === 32'h8000_0014, "R10 pre-reset status", rd, 32'h8000_0014);
        bus_wr(4'd14, 32'h1);
        bus_rd(4'd7, rd);
        chk(rd === 32'h64, "R10 soft reset status", rd, 32'h64);
        for (int a = 0; a < 14; a++) begin
            if (a != 7) begin
                bus_rd(4'(a), rd);
                chk(rd === 32'h0, "R10 register cleared", rd, 32'h0);
            end
        end
        chk(irq === 1'b0, "R10 irq after soft reset", {31'b0, irq}, 32'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule